// File: doc/BRIEF.md
# Shift-Add Coefficient Quantizer

This block quantizes transform coefficients that arrive one per clock, 64 per 8×8 block, in a fixed position order. In the same step it removes the scale factor left by a scaled (multiplier-free) 2-D cosine transform. There is no divider and no multiplier. Each coefficient is multiplied by a per-position constant that stands for 1/(Q·Fe). The constant is built as the signed sum of up to four power-of-two copies of the coefficient. For each position, a constant table holds the barrel-shifter control codes, not the quantization step.

The datapath has four register stages. The first stage reads the table and forms four shifted, optionally negated terms. The second adds the terms in two pairs. The third adds the pairs together with a rounding constant. The fourth drops the fraction bits and presents the result. A position counter follows the stream, and a start-of-block pulse realigns it.

Top module: `qz_shift_quant`

## Requirements
- R1: While reset is asserted and afterwards until a coefficient has passed the pipeline, out_valid is low. The first coefficient accepted after reset is treated as position 0 even without a start pulse.
- R2: Each result equals floor((x·K + 2^(FRAC−1)) / 2^FRAC). Here x is the input coefficient and K is the sum over the four term codes of the position, where each enabled code adds +2^sh, or −2^sh when its subtract bit is set. A term code is 7 bits: bit 6 enables the term, bit 5 selects subtract, bits 4:0 give the shift. The code for position p and term t sits at SHIFT_ROM bits [(4p+t)·7 +: 7].
- R3: A coefficient sampled with in_valid at rising edge n appears on coef_out with out_valid high right after edge n+3, a fixed latency of four register stages.
- R4: The position advances by one for each accepted coefficient, wraps from 63 to 0, and holds during cycles without in_valid.
- R5: A coefficient accepted in the same cycle as blk_start is position 0. A blk_start with in_valid low makes the next accepted coefficient position 0.
- R6: A cycle without in_valid yields exactly one cycle with out_valid low, four stages later. Results leave in input order.
- R7: With the default table, position p = 8i + j uses the four-term nearest-power-of-two decomposition of round(2^FRAC / (Q_STEP·Fe(i)·Fe(j))). Here Fe(k) = c(k) / (2·cos(kπ/16)), with c(0) = 1/√2 and c(k) = 1/2 otherwise. Each result lies within |y|/81 + 0.0005·|y| + |x|/2^(FRAC+1) + 0.5 of the ideal value y = x / (Q_STEP·Fe(i)·Fe(j)).
- R8: A product that lies exactly halfway between two integers rounds toward positive infinity, so +2.5 gives 3 and −2.5 gives −2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| blk_start | input | 1 | Start-of-block pulse that realigns the position to 0 |
| in_valid | input | 1 | coef_in carries a coefficient this cycle |
| coef_in | input | IN_W | Signed transform coefficient |
| out_valid | output | 1 | coef_out carries a quantized result |
| coef_out | output | OUT_W | Signed quantized coefficient |

## Verification
The hardest situation to reach from the ports is an exact tie in the rounding step combined with negative terms. It needs a table entry whose enabled terms subtract, together with an input whose product leaves exactly 2^(FRAC−1) in the fraction bits. The bench uses a small configuration (8-bit input, 8 fraction bits) with a table of its own. That table mixes adds, subtracts, disabled terms and one all-zero position. It then streams every input value through every one of the 64 positions, with periodic idle cycles, so each tie and every counter wrap occurs. A second instance with the default table gets the same stream and is checked against the ideal real-valued quotient. Mid-block start pulses, with and without a coefficient in the same cycle, finish the run.

// File: rtl/qz_pkg.sv
package qz_pkg;

  localparam int NPOS    = 64;
  localparam int NTERM   = 4;
  localparam int SH_BITS = 5;
  localparam int CODE_W  = SH_BITS + 2;
  localparam int ROM_W   = NPOS * NTERM * CODE_W;
  localparam int POS_W   = $clog2(NPOS);

  typedef struct packed {
    logic               en;
    logic               neg;
    logic [SH_BITS-1:0] sh;
  } term_code_t;

  // 1/Fe(k) = 2*cos(k*pi/16)/c(k), scaled by 2^12 and rounded
  function automatic longint inv_fe_q12(input int k);
    case (k)
      0:       return 64'sd11585;
      1:       return 64'sd16069;
      2:       return 64'sd15137;
      3:       return 64'sd13623;
      4:       return 64'sd11585;
      5:       return 64'sd9102;
      6:       return 64'sd6270;
      default: return 64'sd3196;
    endcase
  endfunction

  // Default table: greedy nearest-power-of-two split of each gain
  function automatic logic [ROM_W-1:0] build_rom(input int frac, input int qstep);
    logic [ROM_W-1:0] rom;
    longint           gain;
    longint           den;
    longint           res;
    longint           mag;
    int               e;
    term_code_t       c;
    rom = '0;
    den = longint'(qstep) <<< 24;
    for (int p = 0; p < NPOS; p++) begin
      gain = (inv_fe_q12(p / 8) * inv_fe_q12(p % 8)) <<< frac;
      gain = (gain + den / 2) / den;
      res  = gain;
      for (int t = 0; t < NTERM; t++) begin
        c = '0;
        if (res != 0) begin
          mag = (res < 0) ? -res : res;
          e   = 0;
          while (e < 30 && (longint'(1) <<< (e + 1)) <= mag) e++;
          if ((mag - (longint'(1) <<< e)) > ((longint'(1) <<< (e + 1)) - mag)) e++;
          c.en  = 1'b1;
          c.neg = (res < 0);
          c.sh  = SH_BITS'(e);
          res   = (res < 0) ? res + (longint'(1) <<< e) : res - (longint'(1) <<< e);
        end
        rom[(p * NTERM + t) * CODE_W +: CODE_W] = c;
      end
    end
    return rom;
  endfunction

endpackage

// File: rtl/qz_pos_ctr.sv
module qz_pos_ctr
  import qz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             in_valid,
  output logic [POS_W-1:0] pos_use
);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;
  logic             pos_en;

  always_comb begin
    pos_en  = in_valid | blk_start;
    pos_use = blk_start ? '0 : pos_q;
    if (blk_start)
      pos_nxt = in_valid ? POS_W'(1) : '0;
    else if (pos_q == POS_W'(NPOS - 1))
      pos_nxt = '0;
    else
      pos_nxt = pos_q + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_nxt;
  end

  // R4: wrap at the end of a block
  a_r4_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !blk_start && pos_q == POS_W'(NPOS - 1)) |=> (pos_q == '0));

  // R4: idle cycles leave the position alone
  a_r4_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !blk_start) |=> $stable(pos_q));

  // R5: start with a coefficient consumes position 0
  a_r5_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && in_valid) |=> (pos_q == POS_W'(1)));

  // R5: start alone arms position 0
  a_r5_start_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !in_valid) |=> (pos_q == '0));

endmodule

// File: rtl/qz_shift_stage.sv
module qz_shift_stage
  import qz_pkg::*;
#(
  parameter int               IN_W      = 12,
  parameter int               ACC_W     = 30,
  parameter logic [ROM_W-1:0] SHIFT_ROM = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic signed [IN_W-1:0]       coef,
  input  logic [POS_W-1:0]             pos,
  output logic                         valid_q,
  output logic [NTERM-1:0][ACC_W-1:0]  term_q
);

  logic signed [ACC_W-1:0]      coef_ext;
  logic [NTERM-1:0][ACC_W-1:0]  term_nxt;

  assign coef_ext = {{(ACC_W - IN_W){coef[IN_W-1]}}, coef};

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    term_code_t              code;
    logic signed [ACC_W-1:0] shifted;

    always_comb begin
      code        = SHIFT_ROM[(int'(pos) * NTERM + t) * CODE_W +: CODE_W];
      shifted     = coef_ext <<< code.sh;
      if (!code.en)      term_nxt[t] = '0;
      else if (code.neg) term_nxt[t] = -shifted;
      else               term_nxt[t] = shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        term_q <= '0;
    else if (in_valid) term_q <= term_nxt;
  end

endmodule

// File: rtl/qz_adder_tree.sv
module qz_adder_tree
  import qz_pkg::*;
#(
  parameter int ACC_W = 30,
  parameter int FRAC  = 14,
  parameter int OUT_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         valid_i,
  input  logic [NTERM-1:0][ACC_W-1:0]  term_i,
  output logic                         valid_o,
  output logic signed [OUT_W-1:0]      result_o
);

  localparam logic [ACC_W-1:0] HALF = {{(ACC_W - 1){1'b0}}, 1'b1} << (FRAC - 1);

  logic                    v2_q, v3_q;
  logic [ACC_W-1:0]        pair0_q, pair1_q, pair0_nxt, pair1_nxt;
  logic [ACC_W-1:0]        sum_q, sum_nxt;
  logic signed [OUT_W-1:0] res_nxt;
  logic                    unused_sum_bits;

  always_comb begin
    pair0_nxt = term_i[0] + term_i[1];
    pair1_nxt = term_i[2] + term_i[3];
    sum_nxt   = pair0_q + pair1_q + HALF;
    res_nxt   = sum_q[FRAC +: OUT_W];
  end

  if (FRAC + OUT_W < ACC_W) begin : g_unused_hi
    assign unused_sum_bits = ^{sum_q[FRAC-1:0], sum_q[ACC_W-1:FRAC+OUT_W]};
  end else begin : g_unused_lo
    assign unused_sum_bits = ^sum_q[FRAC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q    <= 1'b0;
      v3_q    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      v2_q    <= valid_i;
      v3_q    <= v2_q;
      valid_o <= v3_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair0_q <= '0;
      pair1_q <= '0;
    end else if (valid_i) begin
      pair0_q <= pair0_nxt;
      pair1_q <= pair1_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum_q <= '0;
    else if (v2_q) sum_q <= sum_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    result_o <= '0;
    else if (v3_q) result_o <= res_nxt;
  end

endmodule

// File: rtl/qz_shift_quant.sv
module qz_shift_quant
  import qz_pkg::*;
#(
  parameter int               IN_W      = 12,
  parameter int               OUT_W     = 12,
  parameter int               FRAC      = 14,
  parameter int               Q_STEP    = 16,
  parameter logic [ROM_W-1:0] SHIFT_ROM = build_rom(FRAC, Q_STEP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    blk_start,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  coef_in,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] coef_out
);

  localparam int MAX_SH  = FRAC + 1;
  localparam int ACC_A   = IN_W + MAX_SH + 3;
  localparam int ACC_B   = FRAC + OUT_W;
  localparam int ACC_W   = (ACC_A > ACC_B) ? ACC_A : ACC_B;

  logic [POS_W-1:0]             pos_use;
  logic                         s1_valid;
  logic [NTERM-1:0][ACC_W-1:0]  s1_term;

  qz_pos_ctr u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_start (blk_start),
    .in_valid  (in_valid),
    .pos_use   (pos_use)
  );

  qz_shift_stage #(
    .IN_W      (IN_W),
    .ACC_W     (ACC_W),
    .SHIFT_ROM (SHIFT_ROM)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .coef     (coef_in),
    .pos      (pos_use),
    .valid_q  (s1_valid),
    .term_q   (s1_term)
  );

  qz_adder_tree #(
    .ACC_W (ACC_W),
    .FRAC  (FRAC),
    .OUT_W (OUT_W)
  ) u_tree (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (s1_valid),
    .term_i   (s1_term),
    .valid_o  (out_valid),
    .result_o (coef_out)
  );

  // R3: every accepted coefficient emerges four stages later
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_valid);

  // R6: every idle input cycle becomes an idle output cycle
  a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##4 !out_valid);

endmodule

// File: tb/qz_shift_quant_test.sv
`timescale 1ns/1ps
module qz_shift_quant_test;
  import qz_pkg::*;

  localparam int B_IN   = 8;
  localparam int B_OUT  = 13;
  localparam int B_FRAC = 8;
  localparam int D_IN   = 12;
  localparam int D_OUT  = 12;
  localparam int D_FRAC = 14;
  localparam int D_Q    = 16;
  localparam int DEPTH  = 32768;

  function automatic bit c_en(input int p, input int t);
    return (p != 13) && (((p + t) % 5) != 4);
  endfunction
  function automatic bit c_neg(input int p, input int t);
    return ((p >> t) & 1) == 1;
  endfunction
  function automatic int c_sh(input int p, input int t);
    return (p * 3 + t * 7) % (B_FRAC + 2);
  endfunction

  function automatic logic [ROM_W-1:0] bench_rom();
    logic [ROM_W-1:0] r;
    r = '0;
    for (int p = 0; p < NPOS; p++)
      for (int t = 0; t < NTERM; t++)
        r[(p * NTERM + t) * CODE_W +: CODE_W] =
          {c_en(p, t), c_neg(p, t), SH_BITS'(c_sh(p, t))};
    return r;
  endfunction

  function automatic longint bench_gain(input int p);
    longint k;
    k = 0;
    for (int t = 0; t < NTERM; t++)
      if (c_en(p, t))
        k = c_neg(p, t) ? k - (longint'(1) <<< c_sh(p, t)) : k + (longint'(1) <<< c_sh(p, t));
    return k;
  endfunction

  function automatic real fe(input int k);
    real ck;
    ck = (k == 0) ? 1.0 / $sqrt(2.0) : 0.5;
    return ck / (2.0 * $cos(k * 3.14159265358979 / 16.0));
  endfunction

  logic clk, rst_n, blk_start, in_valid;
  logic signed [B_IN-1:0]  coef_b;
  logic signed [D_IN-1:0]  coef_d;
  logic                    ov_b, ov_d;
  logic signed [B_OUT-1:0] out_b;
  logic signed [D_OUT-1:0] out_d;

  qz_shift_quant #(
    .IN_W (B_IN), .OUT_W (B_OUT), .FRAC (B_FRAC), .Q_STEP (16),
    .SHIFT_ROM (bench_rom())
  ) uut (
    .clk (clk), .rst_n (rst_n), .blk_start (blk_start), .in_valid (in_valid),
    .coef_in (coef_b), .out_valid (ov_b), .coef_out (out_b)
  );

  qz_shift_quant uut_def (
    .clk (clk), .rst_n (rst_n), .blk_start (blk_start), .in_valid (in_valid),
    .coef_in (coef_d), .out_valid (ov_d), .coef_out (out_d)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int     n_tests = 0;
  int     n_fail  = 0;
  longint exp_b [DEPTH];
  real    ideal_d [DEPTH];
  int     x_d [DEPTH];
  string  tag_q [DEPTH];
  int     wr = 0;
  int     rd = 0;
  int     pos_m = 0;
  bit     first_seen = 0;
  logic [3:0] vhist = '0;
  bit     done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // reference model: sampled on the rising edge, inputs change on the falling edge
  always @(posedge clk) begin
    if (rst_n) begin
      int     pu;
      longint k, prod;
      string  tg;
      vhist <= {vhist[2:0], in_valid};
      pu = blk_start ? 0 : pos_m;
      if (blk_start) pos_m = in_valid ? 1 : 0;
      else if (in_valid) pos_m = (pos_m + 1) % NPOS;
      if (in_valid) begin
        k    = bench_gain(pu);
        prod = longint'(coef_b) * k;
        exp_b[wr] = (prod + (longint'(1) <<< (B_FRAC - 1))) >>> B_FRAC;
        ideal_d[wr] = real'(coef_d) / (real'(D_Q) * fe(pu / 8) * fe(pu % 8));
        x_d[wr] = int'(coef_d);
        if (blk_start)                                          tg = "R5";
        else if (!first_seen)                                   tg = "R1";
        else if ((prod & ((longint'(1) <<< B_FRAC) - 1)) == (longint'(1) <<< (B_FRAC - 1))) tg = "R8";
        else if (pu == 0)                                       tg = "R4";
        else                                                    tg = "R2";
        tag_q[wr] = tg;
        first_seen = 1;
        wr++;
      end
    end
  end

  // output checker on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ov_b == vhist[3], vhist[3] ? "R3" : "R6", longint'(ov_b), longint'(vhist[3]));
      check(ov_d == vhist[3], "R3", longint'(ov_d), longint'(vhist[3]));
      if (ov_b && vhist[3]) begin
        real y, err, tol;
        check(longint'(out_b) == exp_b[rd], tag_q[rd], longint'(out_b), exp_b[rd]);
        y   = ideal_d[rd];
        err = real'(out_d) - y;
        if (err < 0.0) err = -err;
        tol = ((y < 0.0) ? -y : y) * (1.0 / 81.0 + 0.0005)
            + ((x_d[rd] < 0) ? -x_d[rd] : x_d[rd]) / real'(1 << (D_FRAC + 1)) + 0.5;
        check(err <= tol, "R7", longint'(out_d), longint'($rtoi(y)));
        rd++;
      end
    end
  end

  task automatic drive(input bit v, input bit s, input int x);
    @(negedge clk);
    in_valid  = v;
    blk_start = s;
    coef_b    = B_IN'(x);
    coef_d    = D_IN'(x * 16 + ((x * 5) & 15));
  endtask

  initial begin
    int cyc;
    rst_n = 1'b0; in_valid = 1'b0; blk_start = 1'b0; coef_b = '0; coef_d = '0;
    repeat (3) @(negedge clk);
    check(ov_b == 1'b0 && ov_d == 1'b0, "R1", longint'(ov_b), 0);
    rst_n = 1'b1;
    drive(0, 0, 0); drive(0, 0, 0);
    // full sweep: every value through every position, with bubbles
    cyc = 0;
    for (int xv = -128; xv < 128; xv++) begin
      for (int p = 0; p < NPOS; p++) begin
        if ((cyc % 7) == 6) drive(0, 0, 0);
        drive(1, 0, xv);
        cyc++;
      end
    end
    // mid-block start with a coefficient in the same cycle
    for (int i = 0; i < 10; i++) drive(1, 0, 37 + i);
    drive(1, 1, 101);
    for (int i = 0; i < 5; i++) drive(1, 0, -77 + i);
    // start with no coefficient, then a coefficient
    drive(0, 1, 0);
    drive(0, 0, 0);
    drive(1, 0, 99);
    drive(1, 0, -128);
    for (int i = 0; i < 8; i++) drive(0, 0, 0);
    done = 1;
    check(rd == wr, "R6", longint'(rd), longint'(wr));
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", rd, wr);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule